// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a down-counting interval timer that raises a periodic interrupt. A scale register sets a prescaler. The prescaler divides the core clock, so the main count steps down by one only every (scale + 1) cycles. When a prescaled step finds the count already at zero, the count is refilled from a separate period register and a one-cycle interrupt pulse is produced. The time between interrupts is therefore (period + 1) × (scale + 1) cycles.

Software sets up the timer through a small register port. It loads the scale, period and starting count, then sets an enable bit. While the timer runs, the count can be read back or overwritten at any time. Clearing the enable bit freezes the timer. Setting the enable bit again restarts the prescale interval.

Top module: `interval_timer`

## Requirements
- R1: After reset, the scale, count, period and control registers all read zero and the interrupt output is low.
- R2: With scale value s, while enabled, the count decrements once every s + 1 cycles. A scale of 0 steps the count on every cycle and a scale of 255 steps it once every 256 cycles.
- R3: A prescaled step that finds the count at zero loads the count with the period value instead of decrementing it. With period 0, the count stays at zero and every step reloads.
- R4: The interrupt is asserted for exactly one cycle per reload, in the cycle right after the reload edge (when the count first shows the period value). The first interrupt comes (count + 1) × (scale + 1) cycles after the enable edge, and each later one comes (period + 1) × (scale + 1) cycles after the one before.
- R5: A write to the count register sets the count at the next edge, overrides any decrement or reload in that cycle, and produces no interrupt.
- R6: While the enable bit is clear, the count and the prescaler hold their values and no interrupt is produced.
- R7: A write to the scale register, or setting the enable bit while it is clear, restarts the prescaler from the scale value. The next step then comes scale + 1 cycles after that write edge.
- R8: Register select codes: 0 selects scale (bits 7:0; reads return zero above bit 7), 1 selects count, 2 selects period, and 3 selects control (bit 0 is the enable bit). A read returns the stored value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt pulse on reload |

## Verification
If the prescaler holds a wrong value, the count read back slips by at least one step within at most 256 cycles. It also pushes the next interrupt off the cycle computed from the period and scale. If the count or reload path is wrong, the value read from the count register in the cycle the pulse appears no longer matches the period. A missing restart shows up as a step that arrives early, within one scale interval after the scale write or the re-enable.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    typedef enum logic [1:0] {
        SEL_SCALE  = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_CTRL   = 2'd3
    } tmr_sel_e;

    localparam int unsigned CTRL_EN_BIT = 0;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [SCL_W-1:0] scale_o,
    output logic [CNT_W-1:0] period_o,
    output logic             en_o,
    output logic             cnt_wr_o,
    output logic             restart_o,
    output logic [SCL_W-1:0] load_val_o
);
    typedef struct packed {
        logic [SCL_W-1:0] scale;
        logic [CNT_W-1:0] period;
        logic             en;
    } regs_t;

    regs_t r_d, r_q;
    logic  scl_wr, per_wr, ctl_wr;

    always_comb begin
        scl_wr   = wr_en_i && (wr_sel_i == SEL_SCALE);
        per_wr   = wr_en_i && (wr_sel_i == SEL_PERIOD);
        ctl_wr   = wr_en_i && (wr_sel_i == SEL_CTRL);
        cnt_wr_o = wr_en_i && (wr_sel_i == SEL_COUNT);
        r_d = r_q;
        if (scl_wr) r_d.scale  = wr_data_i[SCL_W-1:0];
        if (per_wr) r_d.period = wr_data_i;
        if (ctl_wr) r_d.en     = wr_data_i[CTRL_EN_BIT];
        restart_o  = scl_wr || (ctl_wr && wr_data_i[CTRL_EN_BIT] && !r_q.en);
        load_val_o = scl_wr ? wr_data_i[SCL_W-1:0] : r_q.scale;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign scale_o  = r_q.scale;
    assign period_o = r_q.period;
    assign en_o     = r_q.en;

    // R8
    scale_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_wr |=> scale_o == $past(wr_data_i[SCL_W-1:0]));
    // R8
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !per_wr |=> $stable(period_o));
endmodule

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
    parameter int unsigned SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [SCL_W-1:0] load_val_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [SCL_W-1:0] div;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = en_i && !restart_i && (s_q.div == '0);
        if (restart_i) begin
            s_d.div = load_val_i;
        end else if (en_i) begin
            if (s_q.div == '0) s_d.div = load_val_i;
            else               s_d.div = s_q.div - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> s_q.div == $past(load_val_i));
    // R6
    prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !restart_i) |=> $stable(s_q.div));
    // R2
    prescale_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !restart_i && s_q.div != '0) |=> s_q.div == SCL_W'($past(s_q.div) - 1'b1));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        if (cnt_wr_i) begin
            c_d.cnt = wr_data_i;
        end else if (tick_i) begin
            if (c_q.cnt == '0) begin
                c_d.cnt = period_i;
                c_d.irq = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_o = c_q.cnt;
    assign irq_o   = c_q.irq;

    // R5
    count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (count_o == $past(wr_data_i)) && !irq_o);
    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_wr_i && count_o == '0) |=> (count_o == $past(period_i)) && irq_o);
    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(count_o) && !irq_o);
    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(tick_i) && ($past(count_o) == '0));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_pulse
);
    localparam int unsigned PAD_W = CNT_W - SCL_W;

    logic [SCL_W-1:0] scale, load_val;
    logic [CNT_W-1:0] period, count;
    logic             en, cnt_wr, restart, tick;

    itmr_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .scale_o    (scale),
        .period_o   (period),
        .en_o       (en),
        .cnt_wr_o   (cnt_wr),
        .restart_o  (restart),
        .load_val_o (load_val)
    );

    itmr_prescale #(.SCL_W(SCL_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .restart_i  (restart),
        .load_val_i (load_val),
        .tick_o     (tick)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .cnt_wr_i  (cnt_wr),
        .wr_data_i (wr_data),
        .period_i  (period),
        .count_o   (count),
        .irq_o     (irq_pulse)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_SCALE:  rd_data = {{PAD_W{1'b0}}, scale};
            SEL_COUNT:  rd_data = count;
            SEL_PERIOD: rd_data = period;
            default:    rd_data = {{(CNT_W-1){1'b0}}, en};
        endcase
    end

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> !irq_pulse);
endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/100ps
module tb_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [1:0]  rd_sel;
    logic [15:0] rd_data;
    logic        irq_pulse;

    int n_chk = 0;
    int n_bad = 0;

    interval_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse)
    );

    always #2 clk = ~clk;

    // {scale[7:0], count[15:0], period[15:0]}
    localparam logic [39:0] VEC [4] = '{
        {8'd0, 16'd3, 16'd5},
        {8'd2, 16'd1, 16'd2},
        {8'd7, 16'd0, 16'd3},
        {8'd1, 16'd4, 16'd0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] val);
        rd_sel = sel;
        #0.5 val = rd_data;
    endtask

    task automatic cyc(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic wait_irq(input int limit, output int n, input int exp_gap);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk); #1;
            n++;
            if (irq_pulse) break;
            if (n == 1 && exp_gap > 1) chk("R4 pulse width", 16'(irq_pulse), 16'd0);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk("R1 reset reg", v, 16'd0);
        end
        chk("R1 reset irq", 16'(irq_pulse), 16'd0);

        // R8 readback
        wr(2'd2, 16'hA5C3); rd(2'd2, v); chk("R8 period", v, 16'hA5C3);
        wr(2'd0, 16'h12FF); rd(2'd0, v); chk("R8 scale width", v, 16'h00FF);

        // R2/R3/R4 table walk
        for (int i = 0; i < 4; i++) begin
            int s, c, p;
            s = int'(VEC[i][39:32]); c = int'(VEC[i][31:16]); p = int'(VEC[i][15:0]);
            wr(2'd3, 16'd0);
            wr(2'd0, 16'(s));
            wr(2'd1, 16'(c));
            wr(2'd2, 16'(p));
            wr(2'd3, 16'd1);
            wait_irq(5000, n, (c + 1) * (s + 1));
            chk("R4 first irq delay", 16'(n), 16'((c + 1) * (s + 1)));
            rd(2'd1, v);
            chk("R3 reload value", v, 16'(p));
            wait_irq(5000, n, (p + 1) * (s + 1));
            chk("R2 irq interval", 16'(n), 16'((p + 1) * (s + 1)));
        end
        wr(2'd3, 16'd0);
        rd(2'd3, v); chk("R8 ctrl cleared", v, 16'd0);

        // R7 prescaler restart on scale write
        wr(2'd0, 16'd3); wr(2'd1, 16'd50); wr(2'd3, 16'd1);
        cyc(5);
        rd(2'd1, v); chk("R2 step at scale+1", v, 16'd49);
        wr(2'd0, 16'd3);
        cyc(3);
        rd(2'd1, v); chk("R7 no early step", v, 16'd49);
        cyc(1);
        rd(2'd1, v); chk("R7 step after restart", v, 16'd48);

        // R6 hold while disabled
        wr(2'd3, 16'd0);
        cyc(20);
        rd(2'd1, v); chk("R6 count held", v, 16'd48);
        wr(2'd3, 16'd1);
        cyc(3);
        rd(2'd1, v); chk("R7 re-enable restart", v, 16'd48);
        cyc(1);
        rd(2'd1, v); chk("R6 resumes", v, 16'd47);

        // R5 count write overrides decrement
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd7);
        rd(2'd1, v); chk("R5 write wins", v, 16'd7);
        cyc(1);
        rd(2'd1, v); chk("R5 then counts", v, 16'd6);
        wr(2'd2, 16'd9);
        wr(2'd1, 16'd0);
        chk("R5 no irq on write", 16'(irq_pulse), 16'd0);
        cyc(1);
        rd(2'd1, v); chk("R3 zero reloads", v, 16'd9);
        chk("R4 irq on reload", 16'(irq_pulse), 16'd1);
        cyc(1);
        chk("R4 single cycle", 16'(irq_pulse), 16'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule